// File: doc/BRIEF.md
# Dual-Mode Multiplexed Bus Slave

This block is the slave side of a byte-wide bus that carries the address and the data on the same eight wires. Each access starts with an address phase, marked by a pulse on the address strobe. It ends with a data phase, in which the block either stores a byte into its 128-byte register/RAM array or drives a byte back onto the bus. The bus pins are split into an input, an output and an output enable, so that a pad ring or a bench can build the tristate driver.

A strap input picks one of two strobe conventions. With the strap high, one line is a data strobe and the other is a read/write level. With the strap low, the same two lines are a read strobe and a write strobe, both active low. Every strobe, the strap and the bus byte pass through a synchronizer into a fast system clock. Every protocol decision is made on edges of the synchronized copies, so each strobe edge acts exactly once. The storage covers four control bytes, the time and alarm bytes and 114 bytes of general RAM. Here it is one flat 128-entry array.

Top module: `mbs_top`

## Requirements
- R1: The strap `bus_type_i` selects the strobe convention: 1 selects the data-strobe/read-write-level convention, and 0 selects the read-strobe/write-strobe convention. Bus levels that drive data in one convention drive nothing in the other.
- R2: The address is taken from `ad_i[6:0]` when the synchronized address strobe falls. `ad_i[7]` is ignored. The address register keeps its value until the next falling edge of the address strobe.
- R3: With the strap at 1, a falling edge of `ds_i` while `rw_i` is 0 and `cs_n_i` is 0 stores the bus byte at the latched address. Each such edge stores the byte exactly once.
- R4: With the strap at 0, a rising edge of `rw_i` (the end of the write strobe) while `cs_n_i` is 0 stores the bus byte at the latched address. Each such edge stores the byte exactly once.
- R5: With the strap at 1, `ad_oe_o` is 1 and `ad_o` carries the addressed byte while `ds_i`, `rw_i` and `!cs_n_i` are all high. The output enable returns to 0 after `ds_i` falls.
- R6: With the strap at 0, `ad_oe_o` is 1 and `ad_o` carries the addressed byte while `ds_i` is low, `rw_i` is high and `cs_n_i` is low. The output enable returns to 0 after `ds_i` rises.
- R7: While `cs_n_i` is 1, no strobe edge changes the array and `ad_oe_o` stays 0.
- R8: An active-low `rst_n` clears the latched address to 0 and `ad_oe_o` to 0, and leaves the array contents unchanged.
- R9: With the default of two synchronizer stages, `ad_oe_o` changes on the third rising clock edge after a strobe input changes, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_type_i | input | 1 | Strobe convention strap, 1 = data strobe plus read/write level, 0 = separate read and write strobes |
| cs_n_i | input | 1 | Chip select, active low |
| as_i | input | 1 | Address strobe, address taken on its falling edge |
| ds_i | input | 1 | Data strobe (strap 1) or read strobe, active low (strap 0) |
| rw_i | input | 1 | Read/write level, 1 = read (strap 1), or write strobe, active low (strap 0) |
| ad_i | input | 8 | Multiplexed address/data bus, input side |
| ad_o | output | 8 | Read data toward the bus |
| ad_oe_o | output | 1 | Drive enable for `ad_o` |

## Verification
The assertions check on every cycle that the address register moves only on an address-strobe edge, that no write commit lasts more than one cycle, that the output enable is never on unless chip select was active, and that it drops after the terminating strobe edge for each convention. Only the bench scenarios can show that data written under one convention reads back correctly under the other. The same holds for the ignored top address bit, for an overwrite showing the newest byte, and for a chip-select-high write leaving the array unchanged. They also show that a reset clears the address while the RAM survives, and they measure the exact three-edge response delay.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

   typedef enum logic {
      MODE_SPLIT = 1'b0,   // separate read and write strobes
      MODE_LEVEL = 1'b1    // data strobe plus read/write level
   } bus_mode_e;

   // bit order of the synchronized control vector
   localparam int CTL_AS   = 0;
   localparam int CTL_DS   = 1;
   localparam int CTL_RW   = 2;
   localparam int CTL_CSN  = 3;
   localparam int CTL_MODE = 4;
   localparam int CTL_W    = 5;

   // reset value: chip deselected, rw high, split mode
   localparam logic [CTL_W-1:0] CTL_RST = 5'b01100;

endpackage

// File: rtl/mbs_sync.sv
module mbs_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   localparam int TOP = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("mbs_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("mbs_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= {STAGES{RST_VAL}};
      end else begin
         stg <= {stg[STAGES-2:0], d};
      end
   end

   assign q = stg[TOP];

endmodule

// File: rtl/mbs_protocol.sv
module mbs_protocol
   import mbs_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTL_W-1:0]  ctl_s,     // synchronized strobes and strap
   input  logic [DATA_W-1:0] data_s,    // synchronized bus byte
   output logic [ADDR_W-1:0] addr_q,
   output logic              wr_fire,
   output logic              oe_q
);

   if (ADDR_W > DATA_W) begin : g_bad_addr
      $error("mbs_protocol: ADDR_W must not exceed DATA_W");
   end

   logic [CTL_W-1:0] ctl_prev;
   bus_mode_e        mode;
   logic             s_as, s_ds, s_rw, s_csn;
   logic             as_fall, ds_fall, ds_rise, rw_rise;
   logic             rd_cond;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_prev <= CTL_RST;
      else        ctl_prev <= ctl_s;
   end

   always_comb begin
      mode    = bus_mode_e'(ctl_s[CTL_MODE]);
      s_as    = ctl_s[CTL_AS];
      s_ds    = ctl_s[CTL_DS];
      s_rw    = ctl_s[CTL_RW];
      s_csn   = ctl_s[CTL_CSN];
      as_fall = ctl_prev[CTL_AS] & ~s_as;
      ds_fall = ctl_prev[CTL_DS] & ~s_ds;
      ds_rise = ~ctl_prev[CTL_DS] & s_ds;
      rw_rise = ~ctl_prev[CTL_RW] & s_rw;
   end

   // commit and drive conditions per strobe convention
   always_comb begin
      if (mode == MODE_LEVEL) begin
         wr_fire = ds_fall & ~s_rw & ~s_csn;
         rd_cond = s_ds & s_rw & ~s_csn;
      end else begin
         wr_fire = rw_rise & ~s_csn;
         rd_cond = ~s_ds & s_rw & ~s_csn;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         oe_q   <= 1'b0;
      end else begin
         if (as_fall) addr_q <= data_s[ADDR_W-1:0];
         oe_q <= rd_cond;
      end
   end

   if (ADDR_W < DATA_W) begin : g_hi_bits
      logic unused_hi;
      assign unused_hi = ^data_s[DATA_W-1:ADDR_W];
   end

   // R2: the address moves only on an address-strobe fall
   a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !as_fall |=> $stable(addr_q));

   // R3 and R4: one commit per strobe edge
   a_r3_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire |=> !wr_fire);

   // R5: data-strobe fall ends a level-mode read
   a_r5_level_read_end: assert property (@(posedge clk) disable iff (!rst_n)
      (ds_fall && mode == MODE_LEVEL) |=> !oe_q);

   // R6: read-strobe release ends a split-mode read
   a_r6_split_read_end: assert property (@(posedge clk) disable iff (!rst_n)
      (ds_rise && mode == MODE_SPLIT) |=> !oe_q);

endmodule

// File: rtl/mbs_store.sv
module mbs_store #(
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 7,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   if (DEPTH > 4096) begin : g_bad_depth
      $error("mbs_store: ADDR_W too large");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   // no reset: contents survive rst_n
   always_ff @(posedge clk) begin
      if (wr_en) mem[addr] <= wr_data;
   end

   if (OUT_REG) begin : g_reg_out
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk) rd_q <= mem[addr];
      assign rd_data = rd_q;
   end else begin : g_comb_out
      assign rd_data = mem[addr];
   end

endmodule

// File: rtl/mbs_top.sv
module mbs_top
   import mbs_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 7,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_type_i,
   input  logic              cs_n_i,
   input  logic              as_i,
   input  logic              ds_i,
   input  logic              rw_i,
   input  logic [DATA_W-1:0] ad_i,
   output logic [DATA_W-1:0] ad_o,
   output logic              ad_oe_o
);

   logic [CTL_W-1:0]  ctl_raw, ctl_s;
   logic [DATA_W-1:0] data_s;
   logic [ADDR_W-1:0] addr_q;
   logic              wr_fire;
   logic              oe_q;

   always_comb begin
      ctl_raw           = '0;
      ctl_raw[CTL_AS]   = as_i;
      ctl_raw[CTL_DS]   = ds_i;
      ctl_raw[CTL_RW]   = rw_i;
      ctl_raw[CTL_CSN]  = cs_n_i;
      ctl_raw[CTL_MODE] = bus_type_i;
   end

   mbs_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) ctl_sync_i (
      .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s));

   // bus byte delayed by the same depth, so it lines up with the strobes
   mbs_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) dat_sync_i (
      .clk(clk), .rst_n(rst_n), .d(ad_i), .q(data_s));

   mbs_protocol #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) proto_i (
      .clk(clk), .rst_n(rst_n), .ctl_s(ctl_s), .data_s(data_s),
      .addr_q(addr_q), .wr_fire(wr_fire), .oe_q(oe_q));

   mbs_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OUT_REG(OUT_REG)) store_i (
      .clk(clk), .wr_en(wr_fire), .addr(addr_q), .wr_data(data_s), .rd_data(ad_o));

   assign ad_oe_o = oe_q;

   // R7: drive only when chip select was active one cycle earlier
   a_r7_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe_o |-> $past(!ctl_s[CTL_CSN]));

   // R7: no commit while deselected
   a_r7_no_write_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_s[CTL_CSN] |-> !wr_fire);

   // R8: reset leaves the drive off and the address at zero
   a_r8_reset_state: assert property (@(posedge clk)
      !rst_n |=> (!ad_oe_o && addr_q == '0));

endmodule

// File: tb/mbs_top_tb_top.sv
module mbs_top_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 8;

   // {write_mode, read_mode, write_addr, read_addr, data, expected}
   localparam logic [33:0] VEC [NVEC] = '{
      {1'b1, 1'b1, 8'h10, 8'h10, 8'hA5, 8'hA5},
      {1'b0, 1'b0, 8'h11, 8'h11, 8'h5A, 8'h5A},
      {1'b1, 1'b0, 8'h7F, 8'h7F, 8'hFF, 8'hFF},
      {1'b0, 1'b1, 8'h00, 8'h00, 8'h01, 8'h01},
      {1'b1, 1'b1, 8'h92, 8'h12, 8'h3C, 8'h3C},
      {1'b0, 1'b0, 8'h33, 8'hB3, 8'hC3, 8'hC3},
      {1'b0, 1'b1, 8'h40, 8'h40, 8'h00, 8'h00},
      {1'b1, 1'b0, 8'h40, 8'h40, 8'h7E, 8'h7E}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_type = 1'b0;
   logic       cs_n = 1'b1;
   logic       as_s = 1'b0;
   logic       ds_s = 1'b1;
   logic       rw_s = 1'b1;
   logic [7:0] ad_in = 8'h00;
   logic [7:0] ad_out;
   logic       ad_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbs_top dut_i (
      .clk(clk), .rst_n(rst_n), .bus_type_i(bus_type), .cs_n_i(cs_n),
      .as_i(as_s), .ds_i(ds_s), .rw_i(rw_s), .ad_i(ad_in),
      .ad_o(ad_out), .ad_oe_o(ad_oe));

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic set_mode(input logic m);
      @(negedge clk);
      cs_n = 1'b1; as_s = 1'b0; rw_s = 1'b1;
      bus_type = m;
      ds_s = m ? 1'b0 : 1'b1;
      wait_cyc(6);
   endtask

   task automatic latch_addr(input logic [7:0] a);
      ad_in = a; as_s = 1'b1; wait_cyc(4);
      as_s = 1'b0; wait_cyc(4);
   endtask

   task automatic do_write(input logic m, input logic [7:0] a, input logic [7:0] d,
                           input logic sel_n);
      set_mode(m);
      cs_n = sel_n;
      latch_addr(a);
      ad_in = d;
      if (m) begin
         rw_s = 1'b0; ds_s = 1'b1; wait_cyc(4);
         ds_s = 1'b0; wait_cyc(4);
         rw_s = 1'b1; wait_cyc(2);
      end else begin
         rw_s = 1'b0; wait_cyc(4);
         rw_s = 1'b1; wait_cyc(4);
      end
      cs_n = 1'b1; wait_cyc(2);
   endtask

   task automatic do_read(input logic m, input logic [7:0] a, input logic do_latch,
                          input logic sel_n, output logic [7:0] d,
                          output logic oe_on, output logic oe_after);
      set_mode(m);
      cs_n = sel_n;
      if (do_latch) latch_addr(a);
      ds_s = m ? 1'b1 : 1'b0;
      wait_cyc(5);
      d = ad_out; oe_on = ad_oe;
      ds_s = m ? 1'b0 : 1'b1;
      wait_cyc(5);
      oe_after = ad_oe;
      cs_n = 1'b1; wait_cyc(2);
   endtask

   initial begin
      logic [7:0] rd;
      logic       oe1, oe2;
      wait_cyc(4);
      // R8: reset state
      check8("R8 oe during reset", {7'd0, ad_oe}, 8'h00);
      rst_n = 1'b1;
      wait_cyc(4);
      check8("R8 oe after reset", {7'd0, ad_oe}, 8'h00);

      // vector table: R2 R3 R4 R5 R6
      for (int v = 0; v < NVEC; v++) begin
         logic       wm, rmode;
         logic [7:0] wa, ra, dd, ee;
         {wm, rmode, wa, ra, dd, ee} = VEC[v];
         do_write(wm, wa, dd, 1'b0);
         do_read(rmode, ra, 1'b1, 1'b0, rd, oe1, oe2);
         check8(rmode ? "R5 level read data" : "R6 split read data", rd, ee);
         check8(rmode ? "R5 level read oe" : "R6 split read oe", {7'd0, oe1}, 8'h01);
         check8(rmode ? "R5 oe after ds fall" : "R6 oe after ds rise", {7'd0, oe2}, 8'h00);
      end

      // R9: response delay of the output enable in level mode
      set_mode(1'b1);
      cs_n = 1'b0;
      latch_addr(8'h10);
      ds_s = 1'b1;
      wait_cyc(2);
      check8("R9 oe not before third edge", {7'd0, ad_oe}, 8'h00);
      wait_cyc(1);
      check8("R9 oe at third edge", {7'd0, ad_oe}, 8'h01);
      ds_s = 1'b0; wait_cyc(5);
      cs_n = 1'b1; wait_cyc(2);

      // R1: read levels of level mode give no drive in split mode
      set_mode(1'b0);
      ds_s = 1'b1; rw_s = 1'b1; cs_n = 1'b0;
      wait_cyc(6);
      check8("R1 split mode ignores level read", {7'd0, ad_oe}, 8'h00);
      bus_type = 1'b1;
      wait_cyc(6);
      check8("R1 level mode drives", {7'd0, ad_oe}, 8'h01);
      check8("R1 level mode data", ad_out, 8'hA5);
      cs_n = 1'b1; wait_cyc(4);

      // R7: writes and reads with chip select high
      do_write(1'b1, 8'h11, 8'hEE, 1'b1);
      do_write(1'b0, 8'h11, 8'hDD, 1'b1);
      do_read(1'b0, 8'h11, 1'b1, 1'b1, rd, oe1, oe2);
      check8("R7 no oe deselected", {7'd0, oe1}, 8'h00);
      do_read(1'b1, 8'h11, 1'b1, 1'b0, rd, oe1, oe2);
      check8("R7 deselected writes ignored", rd, 8'h5A);

      // R8: reset clears the address, keeps RAM
      do_write(1'b0, 8'h00, 8'h3C, 1'b0);
      set_mode(1'b0);
      latch_addr(8'h55);
      rst_n = 1'b0; wait_cyc(3);
      rst_n = 1'b1; wait_cyc(3);
      do_read(1'b0, 8'h00, 1'b0, 1'b0, rd, oe1, oe2);
      check8("R8 address cleared and RAM kept", rd, 8'h3C);
      check8("R8 read after reset oe", {7'd0, oe1}, 8'h01);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule